// File: doc/BRIEF.md
# Flow Decision Cache Table

This block is a small ternary match table that holds forwarding decisions already worked out by software, so that later packets with the same relevant header bits are handled without software. Each entry stores four things: a mask of the arrival ports it applies to, a header key with a care mask per bit, an action, and a set of state-class tags. The action is an output-port bitmap plus a rewrite selector. The tags name the pieces of local state the decision depended on.

A lookup presents an arrival port and a header key and gets its answer in the same cycle. On a hit the entry's action comes back and the entry becomes the most recently used. On a miss the block raises a punt flag and returns no action; a miss is never resolved in hardware. Software installs entries through a write port, and when a state table changes it issues one invalidate command naming that state class. The command removes every cached decision that carries that class's tag. When no entry is free, an install takes the place of the least recently used entry.

Top module: `fdc_table`

## Requirements
- R1: After a synchronous active-low reset the table holds no valid entries: every lookup misses and `overlap_err` is 0.
- R2: An entry takes part in a lookup only if bit `lk_port` of its ingress-port mask is set. A mask of all ones applies the entry to every port.
- R3: A key bit whose care bit is 0 never affects matching. Where the care bit is 1, the lookup key must equal the stored key, and a care mask of all ones gives an exact match.
- R4: A lookup with no matching entry sets `lk_punt`=1 and `lk_hit`=0, and drives `lk_out_ports`, `lk_rewrite` and `lk_drop` to 0, all in the same cycle.
- R5: A lookup that hits returns the entry's port bitmap and rewrite selector in the same cycle. `lk_drop` is 1 exactly when the hit entry's port bitmap is all zero.
- R6: An invalidate with class c removes, from the next cycle on, every entry whose tag mask has bit c set. Entries without bit c are kept.
- R7: An install whose tag mask has more than MAX_TAGS (4) bits set is ignored. An install with exactly 4 bits set is accepted.
- R8: An install never evicts a valid entry while some entry is invalid. When every entry is valid, the install replaces the entry least recently hit or installed.
- R9: When an invalidate and an install arrive in the same cycle, the invalidate is applied first. The new entry may take a slot freed by it, and the new entry stays valid even if it carries the invalidated class.
- R10: If more than one entry matches a lookup, the lowest-index entry supplies the action. `overlap_err` is then set from the next cycle and stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_valid | input | 1 | Lookup request this cycle |
| lk_port | input | PORT_W | Arrival port index of the looked-up packet |
| lk_key | input | KEY_W | Header key to match |
| lk_hit | output | 1 | Lookup matched an entry |
| lk_punt | output | 1 | Lookup missed; the packet goes to software |
| lk_drop | output | 1 | Hit with an empty port bitmap (drop) |
| lk_out_ports | output | N_PORTS | Output-port bitmap of the hit entry |
| lk_rewrite | output | RWR_W | Rewrite selector of the hit entry |
| ins_valid | input | 1 | Install request |
| ins_port_mask | input | N_PORTS | Ingress ports the new entry applies to |
| ins_key | input | KEY_W | Key of the new entry |
| ins_care | input | KEY_W | Care mask of the new entry (1 = compare) |
| ins_out_ports | input | N_PORTS | Output-port bitmap of the new entry |
| ins_rewrite | input | RWR_W | Rewrite selector of the new entry |
| ins_tags | input | N_CLASS | State-class tag mask of the new entry |
| inv_valid | input | 1 | Invalidate request |
| inv_class | input | CLS_W | State class to invalidate |
| overlap_err | output | 1 | Sticky flag: a lookup matched more than one entry |

## Verification
A wrong valid bit or a wrong tag mask shows at the ports on the very next lookup of that key. It appears as a punt where a hit was due, or as a stale action after an invalidate. Corrupted recency state stays hidden until the table is full. It then shows one install later, as the wrong key going missing. The bench therefore fills the table, changes the recency order with hits, and probes every surviving key. The overlap flag and the priority are checked by installing two deliberately overlapping entries. Both are then checked one cycle apart, first the action and then the flag.

// File: rtl/fdc_pkg.sv
// Package: default sizes and shared types for the flow decision cache.
// Assumes: nothing; holds constants and enums only.
package fdc_pkg;
    localparam int DEF_ENTRIES  = 4;
    localparam int DEF_PORTS    = 4;
    localparam int DEF_KEY_W    = 16;
    localparam int DEF_RWR_W    = 3;
    localparam int DEF_CLASSES  = 16;
    localparam int DEF_MAX_TAGS = 4;

    // Where an install takes its slot from.
    typedef enum logic [1:0] {
        SLOT_NONE,
        SLOT_FREE,
        SLOT_LRU
    } slot_src_e;
endpackage

// File: rtl/fdc_match_cell.sv
// Module: ternary compare of one entry against a lookup.
// Assumes: lk_port indexes a bit of port_mask; care bit 1 means compare.
module fdc_match_cell #(
    parameter int N_PORTS = 4,
    parameter int KEY_W   = 16,
    localparam int PORT_W = $clog2(N_PORTS)
) (
    input  logic               en,
    input  logic [N_PORTS-1:0] port_mask,
    input  logic [KEY_W-1:0]   key_q,
    input  logic [KEY_W-1:0]   care_q,
    input  logic [PORT_W-1:0]  lk_port,
    input  logic [KEY_W-1:0]   lk_key,
    output logic               hit
);
    // Entry hits when valid, scoped to the port, and equal on every cared bit.
    assign hit = en & port_mask[lk_port] & ~(|((lk_key ^ key_q) & care_q));
endmodule

// File: rtl/fdc_pick.sv
// Module: lowest-index priority pick over the per-entry match vector.
// Assumes: N >= 2; multi flags more than one request.
module fdc_pick #(
    parameter int N = 4,
    localparam int IW = $clog2(N)
) (
    input  logic [N-1:0]  req,
    output logic          any,
    output logic          multi,
    output logic [IW-1:0] idx
);
    // Scan from the top so that the lowest set index is left in idx.
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IW'(i);
        end
    end

    assign any   = |req;
    assign multi = ($countones(req) > 1);
endmodule

// File: rtl/fdc_lru.sv
// Module: recency ranks per entry and the choice of the install slot.
// Assumes: ranks form a permutation of 0..N-1 (0 = most recent); a hit
// touch is applied before an install touch in the same cycle; a free
// (invalid) slot is always preferred over eviction.
module fdc_lru
    import fdc_pkg::*;
#(
    parameter int N = 4,
    localparam int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hit_touch,
    input  logic [IW-1:0] hit_idx,
    input  logic          ins_touch,
    input  logic [N-1:0]  avail,
    output logic [IW-1:0] slot
);
    localparam logic [IW-1:0] OLDEST = IW'(N - 1);

    logic [N-1:0][IW-1:0] rank_q, rank_hit, rank_ins;
    logic [IW-1:0]        victim, free_idx;
    logic                 has_free;
    slot_src_e            src;

    // Move the hit entry to rank 0 and age the entries that were newer.
    always_comb begin
        rank_hit = rank_q;
        if (hit_touch) begin
            for (int i = 0; i < N; i++) begin
                if (rank_q[i] < rank_q[hit_idx]) rank_hit[i] = rank_q[i] + IW'(1);
            end
            rank_hit[hit_idx] = '0;
        end
    end

    // Find the oldest entry after the hit has been applied.
    always_comb begin
        victim = '0;
        for (int i = 0; i < N; i++) begin
            if (rank_hit[i] == OLDEST) victim = IW'(i);
        end
    end

    // Find the lowest free slot left after invalidation.
    always_comb begin
        free_idx = '0;
        has_free = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (!avail[i]) begin
                free_idx = IW'(i);
                has_free = 1'b1;
            end
        end
    end

    // Choose the install slot: a free slot first, else the oldest entry.
    always_comb begin
        src  = has_free ? SLOT_FREE : SLOT_LRU;
        slot = (src == SLOT_FREE) ? free_idx : victim;
    end

    // Move the installed slot to rank 0 on top of the hit update.
    always_comb begin
        rank_ins = rank_hit;
        if (ins_touch) begin
            for (int i = 0; i < N; i++) begin
                if (rank_hit[i] < rank_hit[slot]) rank_ins[i] = rank_hit[i] + IW'(1);
            end
            rank_ins[slot] = '0;
        end
    end

    // Hold the ranks; reset sets them to the identity permutation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) rank_q[i] <= IW'(i);
        end else begin
            rank_q <= rank_ins;
        end
    end
endmodule

// File: rtl/fdc_table.sv
// Module: flow decision cache table (top).
// Assumes: software installs non-overlapping rules; a lookup answers in
// the same cycle; an invalidate is applied before a same-cycle install;
// installs carrying more than MAX_TAGS tags are dropped.
module fdc_table
    import fdc_pkg::*;
#(
    parameter int N_ENT    = DEF_ENTRIES,
    parameter int N_PORTS  = DEF_PORTS,
    parameter int KEY_W    = DEF_KEY_W,
    parameter int RWR_W    = DEF_RWR_W,
    parameter int N_CLASS  = DEF_CLASSES,
    parameter int MAX_TAGS = DEF_MAX_TAGS,
    localparam int IDX_W   = $clog2(N_ENT),
    localparam int PORT_W  = $clog2(N_PORTS),
    localparam int CLS_W   = $clog2(N_CLASS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               lk_valid,
    input  logic [PORT_W-1:0]  lk_port,
    input  logic [KEY_W-1:0]   lk_key,
    output logic               lk_hit,
    output logic               lk_punt,
    output logic               lk_drop,
    output logic [N_PORTS-1:0] lk_out_ports,
    output logic [RWR_W-1:0]   lk_rewrite,
    input  logic               ins_valid,
    input  logic [N_PORTS-1:0] ins_port_mask,
    input  logic [KEY_W-1:0]   ins_key,
    input  logic [KEY_W-1:0]   ins_care,
    input  logic [N_PORTS-1:0] ins_out_ports,
    input  logic [RWR_W-1:0]   ins_rewrite,
    input  logic [N_CLASS-1:0] ins_tags,
    input  logic               inv_valid,
    input  logic [CLS_W-1:0]   inv_class,
    output logic               overlap_err
);
    logic [N_ENT-1:0]              valid_q;
    logic [N_ENT-1:0][N_PORTS-1:0] pmask_q;
    logic [N_ENT-1:0][KEY_W-1:0]   key_q;
    logic [N_ENT-1:0][KEY_W-1:0]   care_q;
    logic [N_ENT-1:0][N_PORTS-1:0] oport_q;
    logic [N_ENT-1:0][RWR_W-1:0]   rw_q;
    logic [N_ENT-1:0][N_CLASS-1:0] tag_q;

    logic [N_ENT-1:0] match_vec, inv_kill, survive;
    logic             any_match, multi_match, ins_ok;
    logic [IDX_W-1:0] win, slot;

    // One ternary comparator per entry.
    for (genvar e = 0; e < N_ENT; e++) begin : g_cell
        fdc_match_cell #(.N_PORTS(N_PORTS), .KEY_W(KEY_W)) u_cell (
            .en        (valid_q[e]),
            .port_mask (pmask_q[e]),
            .key_q     (key_q[e]),
            .care_q    (care_q[e]),
            .lk_port   (lk_port),
            .lk_key    (lk_key),
            .hit       (match_vec[e])
        );
    end

    fdc_pick #(.N(N_ENT)) u_pick (
        .req   (match_vec),
        .any   (any_match),
        .multi (multi_match),
        .idx   (win)
    );

    // Lookup result: the winning entry's action on a hit, zeros on a miss.
    always_comb begin
        lk_hit       = lk_valid & any_match;
        lk_punt      = lk_valid & ~any_match;
        lk_out_ports = lk_hit ? oport_q[win] : '0;
        lk_rewrite   = lk_hit ? rw_q[win] : '0;
        lk_drop      = lk_hit & ~(|oport_q[win]);
    end

    // Entries killed by the invalidate command, and those that survive it.
    always_comb begin
        for (int i = 0; i < N_ENT; i++) inv_kill[i] = inv_valid & tag_q[i][inv_class];
        survive = valid_q & ~inv_kill;
        ins_ok  = ins_valid && ($countones(ins_tags) <= MAX_TAGS);
    end

    fdc_lru #(.N(N_ENT)) u_lru (
        .clk       (clk),
        .rst_n     (rst_n),
        .hit_touch (lk_hit),
        .hit_idx   (win),
        .ins_touch (ins_ok),
        .avail     (survive),
        .slot      (slot)
    );

    // Valid bits: apply the invalidate first, then set the installed slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else begin
            valid_q <= survive;
            if (ins_ok) valid_q[slot] <= 1'b1;
        end
    end

    // Entry contents: written only by an accepted install.
    always_ff @(posedge clk) begin
        if (ins_ok) begin
            pmask_q[slot] <= ins_port_mask;
            key_q[slot]   <= ins_key;
            care_q[slot]  <= ins_care;
            oport_q[slot] <= ins_out_ports;
            rw_q[slot]    <= ins_rewrite;
            tag_q[slot]   <= ins_tags;
        end
    end

    // Sticky overlap flag: set by any multi-match lookup.
    always_ff @(posedge clk) begin
        if (!rst_n)                       overlap_err <= 1'b0;
        else if (lk_valid && multi_match) overlap_err <= 1'b1;
    end
endmodule

// File: rtl/fdc_table_chk.sv
// Module: assertion checker for fdc_table, attached with bind below.
// Assumes: it sees the top's ports plus its valid bits and tag masks.
module fdc_table_chk #(
    parameter int N_ENT    = 4,
    parameter int N_PORTS  = 4,
    parameter int RWR_W    = 3,
    parameter int N_CLASS  = 16,
    parameter int MAX_TAGS = 4,
    localparam int CLS_W   = $clog2(N_CLASS)
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          lk_hit,
    input logic                          lk_punt,
    input logic                          lk_drop,
    input logic [N_PORTS-1:0]            lk_out_ports,
    input logic [RWR_W-1:0]              lk_rewrite,
    input logic                          ins_valid,
    input logic                          inv_valid,
    input logic [CLS_W-1:0]              inv_class,
    input logic                          overlap_err,
    input logic [N_ENT-1:0]              valid_q,
    input logic [N_ENT-1:0][N_CLASS-1:0] tag_q
);
    logic [CLS_W-1:0] cls_d;
    logic [N_ENT-1:0] stale;
    logic             over_lim;

    // Remember the class of the previous cycle's invalidate.
    always_ff @(posedge clk) cls_d <= inv_class;

    // Entries still valid with the previous invalidate's class, and entries over the tag limit.
    always_comb begin
        over_lim = 1'b0;
        for (int i = 0; i < N_ENT; i++) begin
            stale[i] = valid_q[i] & tag_q[i][cls_d];
            if (valid_q[i] && ($countones(tag_q[i]) > MAX_TAGS)) over_lim = 1'b1;
        end
    end

    AST_MISS_NO_ACTION: assert property (@(posedge clk) disable iff (!rst_n)
        lk_punt |-> (lk_out_ports == '0 && lk_rewrite == '0 && !lk_drop && !lk_hit)); // R4
    AST_DROP_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        lk_drop |-> (lk_hit && lk_out_ports == '0)); // R5
    AST_INV_CLEARS_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_valid && !ins_valid) |=> (stale == '0)); // R6
    AST_TAG_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        !over_lim); // R7
    AST_OVERLAP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        overlap_err |=> overlap_err); // R10
endmodule

bind fdc_table fdc_table_chk #(
    .N_ENT(N_ENT), .N_PORTS(N_PORTS), .RWR_W(RWR_W),
    .N_CLASS(N_CLASS), .MAX_TAGS(MAX_TAGS)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .lk_hit       (lk_hit),
    .lk_punt      (lk_punt),
    .lk_drop      (lk_drop),
    .lk_out_ports (lk_out_ports),
    .lk_rewrite   (lk_rewrite),
    .ins_valid    (ins_valid),
    .inv_valid    (inv_valid),
    .inv_class    (inv_class),
    .overlap_err  (overlap_err),
    .valid_q      (valid_q),
    .tag_q        (tag_q)
);

// File: tb/fdc_table_tb.sv
`timescale 1ns/1ps
// Bench: a vector table of lookups first, then directed tests.
module fdc_table_tb;
    localparam time CLK_PER = 20ns;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        lk_valid;
    logic [1:0]  lk_port;
    logic [15:0] lk_key;
    logic        lk_hit, lk_punt, lk_drop;
    logic [3:0]  lk_out_ports;
    logic [2:0]  lk_rewrite;
    logic        ins_valid;
    logic [3:0]  ins_port_mask;
    logic [15:0] ins_key, ins_care;
    logic [3:0]  ins_out_ports;
    logic [2:0]  ins_rewrite;
    logic [15:0] ins_tags;
    logic        inv_valid;
    logic [3:0]  inv_class;
    logic        overlap_err;

    int checks = 0;
    int errors = 0;

    always #(CLK_PER / 2) clk = ~clk;

    fdc_table u_dut (
        .clk(clk), .rst_n(rst_n),
        .lk_valid(lk_valid), .lk_port(lk_port), .lk_key(lk_key),
        .lk_hit(lk_hit), .lk_punt(lk_punt), .lk_drop(lk_drop),
        .lk_out_ports(lk_out_ports), .lk_rewrite(lk_rewrite),
        .ins_valid(ins_valid), .ins_port_mask(ins_port_mask), .ins_key(ins_key),
        .ins_care(ins_care), .ins_out_ports(ins_out_ports), .ins_rewrite(ins_rewrite),
        .ins_tags(ins_tags), .inv_valid(inv_valid), .inv_class(inv_class),
        .overlap_err(overlap_err)
    );

    // Lookup vectors: {port[2], key[16], hit[1], ports[4], rewrite[3]}
    localparam logic [25:0] VEC [8] = '{
        {2'd0, 16'h1234, 1'b1, 4'b0010, 3'd1},
        {2'd1, 16'h1234, 1'b0, 4'b0000, 3'd0},
        {2'd2, 16'hAB55, 1'b1, 4'b0000, 3'd0},
        {2'd0, 16'hABFF, 1'b1, 4'b0000, 3'd0},
        {2'd3, 16'h0F0F, 1'b1, 4'b1001, 3'd5},
        {2'd1, 16'h0F0F, 1'b0, 4'b0000, 3'd0},
        {2'd0, 16'h1235, 1'b0, 4'b0000, 3'd0},
        {2'd2, 16'hAC00, 1'b0, 4'b0000, 3'd0}
    };

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        lk_valid = 1'b0; lk_port = '0; lk_key = '0;
        ins_valid = 1'b0; ins_port_mask = '0; ins_key = '0; ins_care = '0;
        ins_out_ports = '0; ins_rewrite = '0; ins_tags = '0;
        inv_valid = 1'b0; inv_class = '0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        idle_inputs();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Lookup driven at a negedge, checked 2 ns later; it commits at the next posedge.
    task automatic lookup(input logic [1:0] port, input logic [15:0] key, input bit hit,
                          input logic [3:0] ports, input logic [2:0] rw, input string req);
        logic [9:0] exp_v, act_v;
        @(negedge clk);
        lk_valid = 1'b1; lk_port = port; lk_key = key;
        #2;
        exp_v = {hit, !hit, hit && ports == 4'b0, (hit ? ports : 4'b0), (hit ? rw : 3'b0)};
        act_v = {lk_hit, lk_punt, lk_drop, lk_out_ports, lk_rewrite};
        chk(act_v === exp_v, req, 32'(act_v), 32'(exp_v));
        @(posedge clk);
        #1 lk_valid = 1'b0;
    endtask

    task automatic install(input logic [3:0] pm, input logic [15:0] key, input logic [15:0] care,
                           input logic [3:0] ports, input logic [2:0] rw, input logic [15:0] tags,
                           input bit with_inv, input logic [3:0] cls);
        @(negedge clk);
        ins_valid = 1'b1; ins_port_mask = pm; ins_key = key; ins_care = care;
        ins_out_ports = ports; ins_rewrite = rw; ins_tags = tags;
        inv_valid = with_inv; inv_class = cls;
        @(posedge clk);
        #1 ins_valid = 1'b0; inv_valid = 1'b0;
    endtask

    task automatic invalidate(input logic [3:0] cls);
        @(negedge clk);
        inv_valid = 1'b1; inv_class = cls;
        @(posedge clk);
        #1 inv_valid = 1'b0;
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        #(CLK_PER * 150000);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        idle_inputs();
        rst_n = 1'b0;
        do_reset();

        // R1: empty after reset
        lookup(2'd0, 16'h1234, 1'b0, 4'b0, 3'd0, "R1 empty table");
        chk(overlap_err == 1'b0, "R1 overlap_err", 32'(overlap_err), 32'd0);

        // Entries A (port 0, exact), B (all ports, high byte), C (ports 2,3, exact)
        install(4'b0001, 16'h1234, 16'hFFFF, 4'b0010, 3'd1, 16'h0001, 1'b0, 4'd0);
        install(4'b1111, 16'hAB00, 16'hFF00, 4'b0000, 3'd0, 16'h0006, 1'b0, 4'd0);
        install(4'b1100, 16'h0F0F, 16'hFFFF, 4'b1001, 3'd5, 16'h0004, 1'b0, 4'd0);

        for (int v = 0; v < 8; v++)
            lookup(VEC[v][25:24], VEC[v][23:8], VEC[v][7], VEC[v][6:3], VEC[v][2:0],
                   "R2 R3 R4 R5 vector");

        // R7: five tags rejected, four accepted
        install(4'b1111, 16'h7777, 16'hFFFF, 4'b0001, 3'd2, 16'h001F, 1'b0, 4'd0);
        lookup(2'd1, 16'h7777, 1'b0, 4'b0, 3'd0, "R7 over limit ignored");
        install(4'b1111, 16'h7778, 16'hFFFF, 4'b0001, 3'd2, 16'h00F0, 1'b0, 4'd0);
        lookup(2'd1, 16'h7778, 1'b1, 4'b0001, 3'd2, "R7 four tags accepted");

        // R6: class 2 removes B and C, keeps A
        invalidate(4'd2);
        lookup(2'd2, 16'hAB55, 1'b0, 4'b0, 3'd0, "R6 B removed");
        lookup(2'd3, 16'h0F0F, 1'b0, 4'b0, 3'd0, "R6 C removed");
        lookup(2'd0, 16'h1234, 1'b1, 4'b0010, 3'd1, "R6 A kept");

        // R9: invalidate class 0 and install D tagged class 0 together
        install(4'b1111, 16'h4242, 16'hFFFF, 4'b0100, 3'd6, 16'h0001, 1'b1, 4'd0);
        lookup(2'd0, 16'h1234, 1'b0, 4'b0, 3'd0, "R9 A invalidated");
        lookup(2'd3, 16'h4242, 1'b1, 4'b0100, 3'd6, "R9 D survives");

        // R8: fill, hit K0, install K4 evicts K1
        do_reset();
        for (int i = 0; i < 4; i++)
            install(4'b1111, 16'hC000 + 16'(i), 16'hFFFF, 4'(1 + i), 3'(i), 16'(1 << (4 + i)), 1'b0, 4'd0);
        lookup(2'd0, 16'hC000, 1'b1, 4'd1, 3'd0, "R8 touch K0");
        install(4'b1111, 16'hC004, 16'hFFFF, 4'd5, 3'd4, 16'h0100, 1'b0, 4'd0);
        lookup(2'd0, 16'hC001, 1'b0, 4'b0, 3'd0, "R8 LRU K1 evicted");
        lookup(2'd0, 16'hC000, 1'b1, 4'd1, 3'd0, "R8 K0 kept");
        lookup(2'd0, 16'hC002, 1'b1, 4'd3, 3'd2, "R8 K2 kept");
        lookup(2'd0, 16'hC003, 1'b1, 4'd4, 3'd3, "R8 K3 kept");
        lookup(2'd0, 16'hC004, 1'b1, 4'd5, 3'd4, "R8 K4 installed");

        // R8: a freed slot is used before any eviction
        invalidate(4'd6);
        lookup(2'd1, 16'hC002, 1'b0, 4'b0, 3'd0, "R6 K2 removed");
        install(4'b1111, 16'hC005, 16'hFFFF, 4'd6, 3'd5, 16'h0200, 1'b0, 4'd0);
        lookup(2'd1, 16'hC000, 1'b1, 4'd1, 3'd0, "R8 free slot K0");
        lookup(2'd1, 16'hC003, 1'b1, 4'd4, 3'd3, "R8 free slot K3");
        lookup(2'd1, 16'hC004, 1'b1, 4'd5, 3'd4, "R8 free slot K4");
        lookup(2'd1, 16'hC005, 1'b1, 4'd6, 3'd5, "R8 free slot K5");

        // R10: overlapping entries, lowest index wins, sticky flag
        do_reset();
        install(4'b1111, 16'h5500, 16'hFF00, 4'b0001, 3'd2, 16'h0001, 1'b0, 4'd0);
        install(4'b1111, 16'h5511, 16'hFFFF, 4'b0100, 3'd3, 16'h0002, 1'b0, 4'd0);
        chk(overlap_err == 1'b0, "R10 flag clear before", 32'(overlap_err), 32'd0);
        lookup(2'd2, 16'h5511, 1'b1, 4'b0001, 3'd2, "R10 lowest index wins");
        #2;
        chk(overlap_err == 1'b1, "R10 flag set", 32'(overlap_err), 32'd1);
        lookup(2'd2, 16'h5522, 1'b1, 4'b0001, 3'd2, "R10 single match");
        lookup(2'd2, 16'h6600, 1'b0, 4'b0, 3'd0, "R4 miss");
        #2;
        chk(overlap_err == 1'b1, "R10 flag sticky", 32'(overlap_err), 32'd1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule